// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the register front end of one 8-input, 8259-style interrupt controller. A small synchronous bus with three live addresses (command, data and trigger-mode) reaches it. Writes to the command and data addresses run the four-step initialization sequence. After that sequence they act as operation words that load the input mask, control priority rotation, issue end-of-interrupt requests and steer the read path. The resulting mode and control fields go out on plain outputs to a separate priority core. That core keeps the request and in-service registers, resolves priority and reports poll and EOI results back through inputs.

The initialization sequence is strict. A first word that asks for single (non-cascaded) operation is refused. A fourth word that does not select microprocessor mode is also refused. In both cases the controller stays not-ready, and the core's interrupt request is blocked from the output. A per-controller trigger-mode register sits at its own address. Its reserved bits are forced to zero, and a parameter selects between the primary and the secondary reserved pattern.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset, ready, mask, vector base, automatic EOI, special nested, special mask, rotate and the trigger-mode register are all 0, and the priority pointer is 7.
- R2: A command-address write with bit 4 set (first init word) clears ready, mask, special mask, the read select and any armed poll. It sets the priority pointer to 7 and raises `init_clr_o` for exactly the following cycle. All of this happens even when the word is refused.
- R3: A first init word with bit 1 set (single mode) is refused. The controller stays not-ready, data-address writes change neither the vector base nor the mask, and operation words are ignored until a new first word arrives.
- R4: The data write that follows an accepted first word loads the vector base with bits 7:3 of the data and zeros in bits 2:0. The next data write (third word) changes no output.
- R5: The fourth init word sets ready only if its bit 0 is 1. It then loads automatic EOI from bit 1 and special nested from bit 4. With bit 0 clear, the controller returns to not-ready and waits for a new first word.
- R6: While ready, a data-address write loads all 8 bits of the mask and leaves the vector base unchanged.
- R7: While ready, a command write with bits 4 and 3 clear loads rotate from bit 7. With bit 5 set and bit 6 clear, it pulses `eoi_ns_o` in the next cycle. With bits 6 and 7 both set, it loads the priority pointer from bits 2:0; bit 6 alone leaves the pointer unchanged.
- R8: While ready, a command write with bit 4 clear and bit 3 set does three things. If bit 6 is 1, special mask takes bit 5; if bit 6 is 0, special mask is unchanged. If bit 1 is 1, the read select takes bit 0 (1 = in-service). Bit 2 arms a poll.
- R9: With no poll armed, a data-address read returns the mask. A command-address read returns `core_isr_i` when the read select is 1 and `core_irr_i` otherwise. A trigger-mode read returns that register. Read data is combinational while `bus_rd_i` is high.
- R10: An armed poll is consumed by the next command- or data-address read. That read returns 0x80 ORed with `poll_pin_i` when `poll_hit_i` is 1, and 0x00 otherwise. The following read is normal.
- R11: A trigger-mode write keeps only the bits of mask 0xF8 on a primary controller and of 0xDE on a secondary one.
- R12: `int_out_o` equals `int_req_i` while ready and is 0 while not ready.
- R13: When `eoi_done_i` is high and rotate is 1, the priority pointer loads `eoi_pin_i`. When rotate is 0, the pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | 0 command, 1 data, 2 trigger-mode, 3 unused |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0 when no read |
| core_irr_i | input | 8 | Request register from the core |
| core_isr_i | input | 8 | In-service register from the core |
| poll_hit_i | input | 1 | Core has an eligible request |
| poll_pin_i | input | 3 | Highest eligible input from the core |
| eoi_done_i | input | 1 | Core retired an in-service bit |
| eoi_pin_i | input | 3 | Input retired by the core |
| int_req_i | input | 1 | Core interrupt request |
| int_out_o | output | 1 | Gated interrupt request |
| ready_o | output | 1 | Initialization complete |
| init_clr_o | output | 1 | One-cycle request-clear strobe to the core |
| vec_base_o | output | 8 | Vector base |
| mask_o | output | 8 | Input mask |
| auto_eoi_o | output | 1 | Automatic EOI mode |
| spec_nested_o | output | 1 | Special fully-nested mode |
| spec_mask_o | output | 1 | Special mask mode |
| rotate_o | output | 1 | Rotation enabled |
| low_prio_o | output | 3 | Lowest-priority input pointer |
| eoi_ns_o | output | 1 | Non-specific EOI strobe |
| trig_mode_o | output | 8 | Edge/level selection per input |

## Verification
On every cycle the assertions check several fixed relations. A first init word clears the listed state and raises the clear strobe. The interrupt output never rises while not-ready. Ready rises only on a data write with bit 0 set. A mask write while ready lands in full and leaves the vector base alone. A trigger-mode write keeps only the reserved-pattern bits, and a non-specific EOI word produces its strobe. Only the bench scenarios show the rest, which depends on history: rejected sequences that must lock out later writes, the read select and the armed poll persisting across several reads, the one-shot consumption of a poll, and the pointer following retired inputs only while rotation is on.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int NPIN  = 8;
  localparam int PIN_W = $clog2(NPIN);

  typedef enum logic [1:0] {
    ADR_CMD  = 2'd0,
    ADR_DATA = 2'd1,
    ADR_TRIG = 2'd2,
    ADR_NONE = 2'd3
  } bus_addr_e;

  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_W2   = 3'd1,
    SEQ_W3   = 3'd2,
    SEQ_W4   = 3'd3,
    SEQ_RUN  = 3'd4
  } init_state_e;

  // command word discrimination
  localparam int CW_INIT_BIT = 4;
  localparam int CW_OP3_BIT  = 3;
  // first init word
  localparam int W1_SINGLE_BIT = 1;
  // fourth init word
  localparam int W4_UPM_BIT  = 0;
  localparam int W4_AEOI_BIT = 1;
  localparam int W4_SFN_BIT  = 4;
  // priority/EOI word
  localparam int OP2_ROT_BIT = 7;
  localparam int OP2_LVL_BIT = 6;
  localparam int OP2_EOI_BIT = 5;
  // read/mode word
  localparam int OP3_ESM_BIT  = 6;
  localparam int OP3_SM_BIT   = 5;
  localparam int OP3_POLL_BIT = 2;
  localparam int OP3_RSEL_BIT = 1;
  localparam int OP3_ISR_BIT  = 0;

  localparam logic [NPIN-1:0] TRIG_KEEP_PRI = 8'hF8;
  localparam logic [NPIN-1:0] TRIG_KEEP_SEC = 8'hDE;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_wr_i,
  input  logic            data_wr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic            ready_o,
  output logic            init_clr_o,
  output logic [NPIN-1:0] vec_base_o,
  output logic            auto_eoi_o,
  output logic            spec_nested_o
);
  localparam int BASE_LSB = PIN_W;

  init_state_e     state_q, state_d;
  logic [NPIN-1:0] base_q, base_d;
  logic            aeoi_q, aeoi_d;
  logic            sfn_q, sfn_d;
  logic            clr_q, clr_d;
  logic            cfg_en;

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    aeoi_d  = aeoi_q;
    sfn_d   = sfn_q;
    clr_d   = 1'b0;
    if (init_wr_i) begin
      clr_d   = 1'b1;
      state_d = wdata_i[W1_SINGLE_BIT] ? SEQ_IDLE : SEQ_W2;
    end else if (data_wr_i) begin
      unique case (state_q)
        SEQ_W2: begin
          base_d  = {wdata_i[NPIN-1:BASE_LSB], {BASE_LSB{1'b0}}};
          state_d = SEQ_W3;
        end
        SEQ_W3: state_d = SEQ_W4;
        SEQ_W4: begin
          if (wdata_i[W4_UPM_BIT]) begin
            aeoi_d  = wdata_i[W4_AEOI_BIT];
            sfn_d   = wdata_i[W4_SFN_BIT];
            state_d = SEQ_RUN;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  assign cfg_en = init_wr_i | data_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      base_q  <= '0;
      aeoi_q  <= 1'b0;
      sfn_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= clr_d;
      if (cfg_en) begin
        state_q <= state_d;
        base_q  <= base_d;
        aeoi_q  <= aeoi_d;
        sfn_q   <= sfn_d;
      end
    end
  end

  assign ready_o       = (state_q == SEQ_RUN);
  assign init_clr_o    = clr_q;
  assign vec_base_o    = base_q;
  assign auto_eoi_o    = aeoi_q;
  assign spec_nested_o = sfn_q;
endmodule

// File: rtl/pic_op_regs.sv
module pic_op_regs
  import pic_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_wr_i,
  input  logic             mask_wr_i,
  input  logic             prio_wr_i,
  input  logic             rdmode_wr_i,
  input  logic             port_rd_i,
  input  logic [NPIN-1:0]  wdata_i,
  input  logic             eoi_done_i,
  input  logic [PIN_W-1:0] eoi_pin_i,
  output logic [NPIN-1:0]  mask_o,
  output logic             rotate_o,
  output logic [PIN_W-1:0] low_prio_o,
  output logic             spec_mask_o,
  output logic             isr_sel_o,
  output logic             poll_armed_o,
  output logic             eoi_ns_o
);
  localparam logic [PIN_W-1:0] PTR_RESET = PIN_W'(NPIN - 1);

  logic [NPIN-1:0]  mask_q, mask_d;
  logic             rot_q, rot_d;
  logic [PIN_W-1:0] lp_q, lp_d;
  logic             smm_q, smm_d;
  logic             sel_q, sel_d;
  logic             poll_q, poll_d;
  logic             eoi_q, eoi_d;
  logic             reg_en;

  always_comb begin
    mask_d = mask_q;
    rot_d  = rot_q;
    lp_d   = lp_q;
    smm_d  = smm_q;
    sel_d  = sel_q;
    poll_d = poll_q;
    eoi_d  = 1'b0;

    if (eoi_done_i && rot_q) lp_d = eoi_pin_i;
    if (port_rd_i) poll_d = 1'b0;

    if (init_wr_i) begin
      mask_d = '0;
      smm_d  = 1'b0;
      sel_d  = 1'b0;
      poll_d = 1'b0;
      lp_d   = PTR_RESET;
    end else if (mask_wr_i) begin
      mask_d = wdata_i;
    end else if (prio_wr_i) begin
      rot_d = wdata_i[OP2_ROT_BIT];
      if (wdata_i[OP2_EOI_BIT] && !wdata_i[OP2_LVL_BIT]) begin
        eoi_d = 1'b1;
      end else if (wdata_i[OP2_LVL_BIT] && wdata_i[OP2_ROT_BIT]) begin
        lp_d = wdata_i[PIN_W-1:0];
      end
    end else if (rdmode_wr_i) begin
      if (wdata_i[OP3_ESM_BIT])  smm_d = wdata_i[OP3_SM_BIT];
      if (wdata_i[OP3_RSEL_BIT]) sel_d = wdata_i[OP3_ISR_BIT];
      poll_d = wdata_i[OP3_POLL_BIT];
    end
  end

  assign reg_en = init_wr_i | mask_wr_i | prio_wr_i | rdmode_wr_i |
                  port_rd_i | eoi_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rot_q  <= 1'b0;
      lp_q   <= PTR_RESET;
      smm_q  <= 1'b0;
      sel_q  <= 1'b0;
      poll_q <= 1'b0;
      eoi_q  <= 1'b0;
    end else begin
      eoi_q <= eoi_d;
      if (reg_en) begin
        mask_q <= mask_d;
        rot_q  <= rot_d;
        lp_q   <= lp_d;
        smm_q  <= smm_d;
        sel_q  <= sel_d;
        poll_q <= poll_d;
      end
    end
  end

  assign mask_o       = mask_q;
  assign rotate_o     = rot_q;
  assign low_prio_o   = lp_q;
  assign spec_mask_o  = smm_q;
  assign isr_sel_o    = sel_q;
  assign poll_armed_o = poll_q;
  assign eoi_ns_o     = eoi_q;
endmodule

// File: rtl/pic_trig_reg.sv
module pic_trig_reg
  import pic_cmd_pkg::*;
#(
  parameter bit IS_SECONDARY = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] trig_o
);
  logic [NPIN-1:0] keep;
  logic [NPIN-1:0] trig_q, trig_d;

  generate
    if (IS_SECONDARY) begin : g_sec
      assign keep = TRIG_KEEP_SEC;
    end else begin : g_pri
      assign keep = TRIG_KEEP_PRI;
    end
  endgenerate

  always_comb begin
    trig_d = wdata_i & keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
    end else if (wr_i) begin
      trig_q <= trig_d;
    end
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
#(
  parameter bit IS_SECONDARY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [NPIN-1:0]  bus_wdata_i,
  output logic [NPIN-1:0]  bus_rdata_o,
  input  logic [NPIN-1:0]  core_irr_i,
  input  logic [NPIN-1:0]  core_isr_i,
  input  logic             poll_hit_i,
  input  logic [PIN_W-1:0] poll_pin_i,
  input  logic             eoi_done_i,
  input  logic [PIN_W-1:0] eoi_pin_i,
  input  logic             int_req_i,
  output logic             int_out_o,
  output logic             ready_o,
  output logic             init_clr_o,
  output logic [NPIN-1:0]  vec_base_o,
  output logic [NPIN-1:0]  mask_o,
  output logic             auto_eoi_o,
  output logic             spec_nested_o,
  output logic             spec_mask_o,
  output logic             rotate_o,
  output logic [PIN_W-1:0] low_prio_o,
  output logic             eoi_ns_o,
  output logic [NPIN-1:0]  trig_mode_o
);
  localparam int POLL_PAD = NPIN - 1 - PIN_W;

  logic wr_cmd, wr_data, wr_trig;
  logic init_wr, mask_wr, prio_wr, rdmode_wr, port_rd;
  logic ready, isr_sel, poll_armed;
  logic [NPIN-1:0] poll_word;
  logic [NPIN-1:0] rd_mux;

  assign wr_cmd  = bus_wr_i && (bus_addr_i == ADR_CMD);
  assign wr_data = bus_wr_i && (bus_addr_i == ADR_DATA);
  assign wr_trig = bus_wr_i && (bus_addr_i == ADR_TRIG);

  assign init_wr   = wr_cmd && bus_wdata_i[CW_INIT_BIT];
  assign prio_wr   = wr_cmd && ready && !bus_wdata_i[CW_INIT_BIT] &&
                     !bus_wdata_i[CW_OP3_BIT];
  assign rdmode_wr = wr_cmd && ready && !bus_wdata_i[CW_INIT_BIT] &&
                     bus_wdata_i[CW_OP3_BIT];
  assign mask_wr   = wr_data && ready;
  assign port_rd   = bus_rd_i &&
                     ((bus_addr_i == ADR_CMD) || (bus_addr_i == ADR_DATA));

  pic_init_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_wr_i     (init_wr),
    .data_wr_i     (wr_data),
    .wdata_i       (bus_wdata_i),
    .ready_o       (ready),
    .init_clr_o    (init_clr_o),
    .vec_base_o    (vec_base_o),
    .auto_eoi_o    (auto_eoi_o),
    .spec_nested_o (spec_nested_o)
  );

  pic_op_regs u_ops (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_wr_i    (init_wr),
    .mask_wr_i    (mask_wr),
    .prio_wr_i    (prio_wr),
    .rdmode_wr_i  (rdmode_wr),
    .port_rd_i    (port_rd),
    .wdata_i      (bus_wdata_i),
    .eoi_done_i   (eoi_done_i),
    .eoi_pin_i    (eoi_pin_i),
    .mask_o       (mask_o),
    .rotate_o     (rotate_o),
    .low_prio_o   (low_prio_o),
    .spec_mask_o  (spec_mask_o),
    .isr_sel_o    (isr_sel),
    .poll_armed_o (poll_armed),
    .eoi_ns_o     (eoi_ns_o)
  );

  pic_trig_reg #(.IS_SECONDARY(IS_SECONDARY)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_trig),
    .wdata_i (bus_wdata_i),
    .trig_o  (trig_mode_o)
  );

  assign poll_word = poll_hit_i ? {1'b1, {POLL_PAD{1'b0}}, poll_pin_i} : '0;

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr_i)
      ADR_CMD:  rd_mux = poll_armed ? poll_word :
                         (isr_sel ? core_isr_i : core_irr_i);
      ADR_DATA: rd_mux = poll_armed ? poll_word : mask_o;
      ADR_TRIG: rd_mux = trig_mode_o;
      default:  rd_mux = '0;
    endcase
  end

  assign bus_rdata_o = bus_rd_i ? rd_mux : '0;
  assign ready_o     = ready;
  assign int_out_o   = int_req_i && ready;
endmodule

// File: rtl/pic_cmd_chk.sv
module pic_cmd_chk
  import pic_cmd_pkg::*;
#(
  parameter bit IS_SECONDARY = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr_i,
  input logic             bus_wr_i,
  input logic [NPIN-1:0]  bus_wdata_i,
  input logic             int_out_o,
  input logic             ready_o,
  input logic             init_clr_o,
  input logic [NPIN-1:0]  vec_base_o,
  input logic [NPIN-1:0]  mask_o,
  input logic             spec_mask_o,
  input logic [PIN_W-1:0] low_prio_o,
  input logic             eoi_ns_o,
  input logic [NPIN-1:0]  trig_mode_o
);
  localparam logic [NPIN-1:0] KEEP = IS_SECONDARY ? TRIG_KEEP_SEC : TRIG_KEEP_PRI;

  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 2'd0 && bus_wdata_i[4]) |=>
      (!ready_o && mask_o == '0 && low_prio_o == 3'd7 && !spec_mask_o && init_clr_o));

  a_r12_int_gated: assert property (@(posedge clk) disable iff (!rst_n)
    int_out_o |-> ready_o);

  a_r5_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(bus_wr_i && bus_addr_i == 2'd1 && bus_wdata_i[0]));

  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && bus_wr_i && bus_addr_i == 2'd1) |=> (mask_o == $past(bus_wdata_i)));

  a_r6_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> $stable(vec_base_o));

  a_r11_trig_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 2'd2) |=> (trig_mode_o == ($past(bus_wdata_i) & KEEP)));

  a_r7_eoi_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && bus_wr_i && bus_addr_i == 2'd0 && bus_wdata_i[7:3] ==? 5'b?0100) |=>
      eoi_ns_o);
endmodule

bind pic_cmd_if pic_cmd_chk #(.IS_SECONDARY(IS_SECONDARY)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .int_out_o   (int_out_o),
  .ready_o     (ready_o),
  .init_clr_o  (init_clr_o),
  .vec_base_o  (vec_base_o),
  .mask_o      (mask_o),
  .spec_mask_o (spec_mask_o),
  .low_prio_o  (low_prio_o),
  .eoi_ns_o    (eoi_ns_o),
  .trig_mode_o (trig_mode_o)
);

// File: tb/pic_cmd_if_tb_top.sv
module pic_cmd_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] b_addr = '0;
  logic       b_wr = 1'b0, b_rd = 1'b0;
  logic [7:0] b_wd = '0;
  logic [7:0] irr = '0, isr = '0;
  logic       p_hit = 1'b0, e_done = 1'b0, i_req = 1'b0;
  logic [2:0] p_pin = '0, e_pin = '0;

  logic [7:0] rdata, base, mask, trig, trig2, rdata2, base2, mask2;
  logic       int_o, rdy, iclr, aeoi, sfn, smm, rot, eoi;
  logic [2:0] lp;
  logic       int2, rdy2, iclr2, aeoi2, sfn2, smm2, rot2, eoi2;
  logic [2:0] lp2;

  pic_cmd_if dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(b_addr), .bus_wr_i(b_wr), .bus_rd_i(b_rd),
    .bus_wdata_i(b_wd), .bus_rdata_o(rdata), .core_irr_i(irr), .core_isr_i(isr),
    .poll_hit_i(p_hit), .poll_pin_i(p_pin), .eoi_done_i(e_done), .eoi_pin_i(e_pin),
    .int_req_i(i_req), .int_out_o(int_o), .ready_o(rdy), .init_clr_o(iclr),
    .vec_base_o(base), .mask_o(mask), .auto_eoi_o(aeoi), .spec_nested_o(sfn),
    .spec_mask_o(smm), .rotate_o(rot), .low_prio_o(lp), .eoi_ns_o(eoi), .trig_mode_o(trig));

  pic_cmd_if #(.IS_SECONDARY(1'b1)) dut2_i (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(b_addr), .bus_wr_i(b_wr), .bus_rd_i(b_rd),
    .bus_wdata_i(b_wd), .bus_rdata_o(rdata2), .core_irr_i(irr), .core_isr_i(isr),
    .poll_hit_i(p_hit), .poll_pin_i(p_pin), .eoi_done_i(e_done), .eoi_pin_i(e_pin),
    .int_req_i(i_req), .int_out_o(int2), .ready_o(rdy2), .init_clr_o(iclr2),
    .vec_base_o(base2), .mask_o(mask2), .auto_eoi_o(aeoi2), .spec_nested_o(sfn2),
    .spec_mask_o(smm2), .rotate_o(rot2), .low_prio_o(lp2), .eoi_ns_o(eoi2), .trig_mode_o(trig2));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1..3 waiting for words 2..4, 4 running
  int m_phase, m_base, m_mask, m_lp, m_trig_p, m_trig_s;
  bit m_aeoi, m_sfn, m_rot, m_smm, m_sel, m_poll, m_eoi, m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_base = 0; m_mask = 0; m_lp = 7; m_trig_p = 0; m_trig_s = 0;
      m_aeoi = 0; m_sfn = 0; m_rot = 0; m_smm = 0; m_sel = 0; m_poll = 0;
      m_eoi = 0; m_clr = 0;
    end else begin
      bit run;
      run = (m_phase == 4);
      m_eoi = 0; m_clr = 0;
      if (e_done && m_rot) m_lp = e_pin;
      if (b_rd && b_addr < 2) m_poll = 0;
      if (b_wr && b_addr == 2) begin
        m_trig_p = b_wd & 'hF8;
        m_trig_s = b_wd & 'hDE;
      end
      if (b_wr && b_addr == 0 && b_wd[4]) begin
        m_clr = 1; m_mask = 0; m_smm = 0; m_sel = 0; m_poll = 0; m_lp = 7;
        m_phase = b_wd[1] ? 0 : 1;
      end else if (b_wr && b_addr == 1) begin
        if (run) m_mask = b_wd;
        else if (m_phase == 1) begin m_base = (b_wd / 8) * 8; m_phase = 2; end
        else if (m_phase == 2) m_phase = 3;
        else if (m_phase == 3) begin
          if (b_wd[0]) begin m_aeoi = b_wd[1]; m_sfn = b_wd[4]; m_phase = 4; end
          else m_phase = 0;
        end
      end else if (b_wr && b_addr == 0 && run && !b_wd[3]) begin
        m_rot = b_wd[7];
        if (b_wd[5] && !b_wd[6]) m_eoi = 1;
        else if (b_wd[6] && b_wd[7]) m_lp = b_wd[2:0];
      end else if (b_wr && b_addr == 0 && run) begin
        if (b_wd[6]) m_smm = b_wd[5];
        if (b_wd[1]) m_sel = b_wd[0];
        m_poll = b_wd[2];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_rd;
      check("R5", rdy, m_phase == 4);
      check("R4", base, m_base);
      check("R6", mask, m_mask);
      check("R5", aeoi, m_aeoi);
      check("R5", sfn, m_sfn);
      check("R8", smm, m_smm);
      check("R7", rot, m_rot);
      check("R7", lp, m_lp);
      check("R7", eoi, m_eoi);
      check("R2", iclr, m_clr);
      check("R11", trig, m_trig_p);
      check("R11", trig2, m_trig_s);
      check("R12", int_o, i_req && m_phase == 4);
      exp_rd = 0;
      if (b_rd) begin
        if (b_addr < 2 && m_poll) exp_rd = p_hit ? ('h80 | p_pin) : 0;
        else if (b_addr == 0) exp_rd = m_sel ? isr : irr;
        else if (b_addr == 1) exp_rd = m_mask;
        else if (b_addr == 2) exp_rd = m_trig_p;
      end
      check("R9", rdata, exp_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    b_addr = a; b_wd = d; b_wr = 1'b1; b_rd = 1'b0;
    @(posedge clk); #2;
    b_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string req);
    b_addr = a; b_rd = 1'b1; b_wr = 1'b0;
    #1 check(req, rdata, exp);
    @(posedge clk); #2;
    b_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    check("R1", rdy, 0); check("R1", lp, 7); check("R1", mask, 0); check("R1", trig, 0);
    // R3 data write before any init word is ignored
    wr(1, 8'h55);
    check("R3", mask, 0);
    // R3 single-mode first word refused
    i_req = 1'b1;
    wr(0, 8'h12);
    wr(1, 8'h48);
    check("R3", base, 0); check("R3", rdy, 0);
    wr(0, 8'h0B);
    check("R3", rot, 0);
    check("R12", int_o, 0);
    // R2 accepted first word
    wr(0, 8'h11);
    check("R2", iclr, 1);
    @(posedge clk); #2;
    check("R2", iclr, 0);
    wr(1, 8'h6D);
    check("R4", base, 8'h68);
    wr(1, 8'h04);
    check("R4", rdy, 0);
    wr(1, 8'h13);
    check("R5", rdy, 1); check("R5", aeoi, 1); check("R5", sfn, 1);
    check("R12", int_o, 1);
    // R6 mask
    wr(1, 8'hA5);
    check("R6", mask, 8'hA5); check("R6", base, 8'h68);
    rd(1, 8'hA5, "R9");
    // R8/R9 read select
    irr = 8'h3C; isr = 8'h81;
    rd(0, 8'h3C, "R9");
    wr(0, 8'h0B);
    rd(0, 8'h81, "R8");
    rd(0, 8'h81, "R8");
    wr(0, 8'h0A);
    rd(0, 8'h3C, "R8");
    // R8 special mask
    wr(0, 8'h68); check("R8", smm, 1);
    wr(0, 8'h28); check("R8", smm, 1);
    wr(0, 8'h48); check("R8", smm, 0);
    // R7 priority/EOI word
    wr(0, 8'h20); check("R7", eoi, 1); check("R7", rot, 0);
    @(posedge clk); #2; check("R7", eoi, 0);
    wr(0, 8'hC3); check("R7", rot, 1); check("R7", lp, 3); check("R7", eoi, 0);
    wr(0, 8'h45); check("R7", rot, 0); check("R7", lp, 3);
    wr(0, 8'h80); check("R7", rot, 1);
    // R13 rotation follows retired input
    e_done = 1'b1; e_pin = 3'd5;
    @(posedge clk); #2;
    e_done = 1'b0;
    check("R13", lp, 5);
    wr(0, 8'h00);
    e_done = 1'b1; e_pin = 3'd2;
    @(posedge clk); #2;
    e_done = 1'b0;
    check("R13", lp, 5);
    // R10 poll
    p_hit = 1'b1; p_pin = 3'd6;
    wr(0, 8'h0C);
    rd(1, 8'h86, "R10");
    rd(1, 8'hA5, "R10");
    p_hit = 1'b0;
    wr(0, 8'h0C);
    rd(0, 8'h00, "R10");
    rd(0, 8'h3C, "R10");
    // R11 trigger register
    wr(2, 8'hFF);
    check("R11", trig, 8'hF8); check("R11", trig2, 8'hDE);
    rd(2, 8'hF8, "R11");
    wr(2, 8'h27);
    check("R11", trig, 8'h20); check("R11", trig2, 8'h06);
    // R2 re-init clears, R5 refused fourth word
    wr(0, 8'h68);
    wr(0, 8'h0C);
    wr(0, 8'h11);
    check("R2", rdy, 0); check("R2", mask, 0); check("R2", lp, 7); check("R2", smm, 0);
    check("R12", int_o, 0);
    p_hit = 1'b1; p_pin = 3'd1;
    rd(1, 8'h00, "R2");
    wr(1, 8'h20); wr(1, 8'h00); wr(1, 8'h02);
    check("R5", rdy, 0); check("R5", aeoi, 1);
    wr(1, 8'h77);
    check("R5", mask, 0); check("R5", base, 8'h20);
    repeat (2) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule